// File: doc/BRIEF.md
# Super I/O Configuration Decoder

This block is the target side of a legacy-style Super I/O configuration space sitting on a narrow I/O bus. The bus has an address, a write strobe, a read strobe, an 8-bit write byte and an 8-bit read byte. At reset the configuration space is locked. A host opens it by writing a two-byte key to the configuration port. It then programs registers indirectly: it writes an index to the configuration port and moves data through the neighbouring data port. One global register picks which logical device's bank the data port reaches. Other global registers hold power-down control and a soft-reset bit.

Bank 0x03 belongs to the parallel-port device. That bank holds an enable bit, a 16-bit I/O base split into high and low bytes, and a protocol-mode byte. While the device is enabled, three registers answer at the programmed base. Offset 0 is the data latch, offset 1 is a read-only status byte taken from input pins, and offset 2 is the control latch. The window follows the base address, so writing new base bytes moves it.

Every access completes in one cycle and there is no back-pressure. A write takes effect at the clock edge that samples `io_wr`. A read is answered on `io_rdata` at the clock edge that samples `io_rd`. Any address that no decoder claims reads as 0xFF, which is what a floating bus returns. The configuration and data ports take priority over a parallel-port window that overlaps them.

Top module: `sio_cfg_decoder`

## Requirements
- R1: After reset the space is locked, `io_rdata` is 0xFF, the parallel port is disabled with base 0x0378 and mode 0x00, and both power-down bytes are 0x00. `io_rdata` changes only on an edge that samples `io_rd`, and it holds its value otherwise.
- R2: Writing 0x51 and then 0x23 to address 0x3F0 opens the space. While open, a write to 0x3F0 loads the index, a read of 0x3F0 returns the index, and accesses to 0x3F1 reach the register that the index selects.
- R3: After 0x51, a write to 0x3F0 of any value other than 0x23 returns the space to locked. This includes a second 0x51.
- R4: While locked, writes to 0x3F1 change nothing, writes to 0x3F0 other than the key change nothing, and reads of 0x3F0 or 0x3F1 return 0xFF.
- R5: While open, writing 0xBB to 0x3F0 locks the space again and does not load the index.
- R6: Index 0x07 is a full readable and writable byte that selects the device bank. Per-device indices act only when it equals 0x03. In any other bank they read 0x00 and ignore writes.
- R7: Index 0x30 bit 0 is the parallel-port enable. It reads back as 0x00 or 0x01 and drives `lpt_enable_o`.
- R8: Index 0x60 is the high byte of the base and index 0x61 the low byte. Their defaults are 0x03 and 0x78.
- R9: Index 0xF0 is the parallel-port mode byte, default 0x00, and it drives `lpt_mode_o`.
- R10: Index 0x22 is the direct power-down byte and index 0x23 the automatic power-down byte. Both are readable and writable and drive `pwr_direct_o` and `pwr_auto_o`.
- R11: Writing index 0x02 with bit 0 set returns the bank select, enable, base, mode and power-down bytes to their defaults. The space stays open and the parallel-port data and control latches are kept. Index 0x02 reads 0x00, and a write with bit 0 clear has no effect.
- R12: Any index not listed above reads 0x00, and writes to it are dropped.
- R13: While enabled, base+0 is the read/write data latch driving `lpt_data_o`. base+1 reads `lpt_status_i` and ignores writes. base+2 is the read/write control latch driving `lpt_ctrl_o`.
- R14: While disabled, or for addresses outside base..base+2, the parallel-port latches do not change. Reads of unclaimed addresses return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered on the edge that samples io_rd |
| lpt_status_i | input | 8 | Parallel-port status pins |
| lpt_data_o | output | 8 | Parallel-port data latch |
| lpt_ctrl_o | output | 8 | Parallel-port control latch |
| lpt_mode_o | output | 8 | Parallel-port protocol mode byte |
| lpt_enable_o | output | 1 | Parallel-port device enable |
| pwr_direct_o | output | 8 | Direct power-down control byte |
| pwr_auto_o | output | 8 | Automatic power-down control byte |

## Verification
The bench aims at the key sequence first. It writes 0x51 followed by a wrong byte and then a lone 0x23, which catches a design that keeps a half-entered key and later unlocks on one byte. It also writes the data port while locked and then reads that register after a proper unlock, which exposes a design that lets locked writes through. Two further cases target bank gating and relocation. Writes made under a foreign bank must not reach the parallel-port registers. After the base is reprogrammed, the old window must read 0xFF and the new one must answer, which catches a decoder that keeps its reset base hard-wired. Soft reset is tested with bit 0 clear and then set, and the bench confirms the space stays open afterwards and the data latch survives the soft reset.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_KEYED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] KEY_EXIT   = 8'hBB;

  localparam logic [7:0] IX_SRST    = 8'h02;
  localparam logic [7:0] IX_BANK    = 8'h07;
  localparam logic [7:0] IX_PD_DIR  = 8'h22;
  localparam logic [7:0] IX_PD_AUTO = 8'h23;
  localparam logic [7:0] IX_ENABLE  = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [7:0] IX_MODE    = 8'hF0;

  localparam logic [7:0] BANK_LPT   = 8'h03;

  localparam int unsigned LPT_SPAN  = 3;
  localparam int unsigned OFS_DATA  = 0;
  localparam int unsigned OFS_STAT  = 1;
  localparam int unsigned OFS_CTRL  = 2;

  localparam logic [7:0] BUS_IDLE   = 8'hFF;

  typedef struct packed {
    logic [7:0] bank;
    logic       lpt_en;
    logic [7:0] base_hi;
    logic [7:0] base_lo;
    logic [7:0] mode;
    logic [7:0] pd_dir;
    logic [7:0] pd_auto;
  } cfg_regs_t;

  localparam cfg_regs_t CFG_DEFAULTS = '{
    bank:    8'h00,
    lpt_en:  1'b0,
    base_hi: 8'h03,
    base_lo: 8'h78,
    mode:    8'h00,
    pd_dir:  8'h00,
    pd_auto: 8'h00
  };

endpackage

// File: rtl/sio_lock_fsm.sv
module sio_lock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       key_wait,
  output logic [7:0] index_q
);

  lock_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_LOCKED;
      index_q <= 8'h00;
    end else if (port_wr) begin
      case (state_q)
        LK_LOCKED: if (wdata == KEY_FIRST) state_q <= LK_KEYED;
        LK_KEYED:  state_q <= (wdata == KEY_SECOND) ? LK_OPEN : LK_LOCKED;
        LK_OPEN: begin
          if (wdata == KEY_EXIT) state_q <= LK_LOCKED;
          else                   index_q <= wdata;
        end
        default:   state_q <= LK_LOCKED;
      endcase
    end
  end

  assign cfg_open = (state_q == LK_OPEN);
  assign key_wait = (state_q == LK_KEYED);

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_wr,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_val,
  output logic        lpt_en,
  output logic [15:0] lpt_base,
  output logic [7:0]  lpt_mode,
  output logic [7:0]  pd_dir,
  output logic [7:0]  pd_auto
);

  cfg_regs_t regs_q;
  logic      bank_is_lpt;

  assign bank_is_lpt = (regs_q.bank == BANK_LPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= CFG_DEFAULTS;
    end else if (data_wr) begin
      if (index == IX_SRST) begin
        if (wdata[0]) regs_q <= CFG_DEFAULTS;
      end else begin
        case (index)
          IX_BANK:    regs_q.bank    <= wdata;
          IX_PD_DIR:  regs_q.pd_dir  <= wdata;
          IX_PD_AUTO: regs_q.pd_auto <= wdata;
          default: begin
            if (bank_is_lpt) begin
              case (index)
                IX_ENABLE:  regs_q.lpt_en  <= wdata[0];
                IX_BASE_HI: regs_q.base_hi <= wdata;
                IX_BASE_LO: regs_q.base_lo <= wdata;
                IX_MODE:    regs_q.mode    <= wdata;
                default:    ;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    case (index)
      IX_BANK:    rd_val = regs_q.bank;
      IX_PD_DIR:  rd_val = regs_q.pd_dir;
      IX_PD_AUTO: rd_val = regs_q.pd_auto;
      default: begin
        if (bank_is_lpt) begin
          case (index)
            IX_ENABLE:  rd_val = {7'b0, regs_q.lpt_en};
            IX_BASE_HI: rd_val = regs_q.base_hi;
            IX_BASE_LO: rd_val = regs_q.base_lo;
            IX_MODE:    rd_val = regs_q.mode;
            default:    rd_val = 8'h00;
          endcase
        end
      end
    endcase
  end

  assign lpt_en   = regs_q.lpt_en;
  assign lpt_base = {regs_q.base_hi, regs_q.base_lo};
  assign lpt_mode = regs_q.mode;
  assign pd_dir   = regs_q.pd_dir;
  assign pd_auto  = regs_q.pd_auto;

endmodule

// File: rtl/sio_lpt_window.sv
module sio_lpt_window
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [15:0]       base,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        status_i,
  output logic              hit,
  output logic [7:0]        rd_val,
  output logic [7:0]        data_q,
  output logic [7:0]        ctrl_q
);

  localparam logic [ADDR_W-1:0] SPAN_W = ADDR_W'(LPT_SPAN);
  localparam logic [ADDR_W-1:0] O_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] O_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] O_CTRL = ADDR_W'(OFS_CTRL);

  logic [ADDR_W-1:0] offset;

  assign offset = addr - ADDR_W'(base);
  assign hit    = enable && (offset < SPAN_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctrl_q <= 8'h00;
    end else if (wr && hit) begin
      if (offset == O_DATA) data_q <= wdata;
      if (offset == O_CTRL) ctrl_q <= wdata;
    end
  end

  always_comb begin
    rd_val = BUS_IDLE;
    if (offset == O_DATA)      rd_val = data_q;
    else if (offset == O_STAT) rd_val = status_i;
    else if (offset == O_CTRL) rd_val = ctrl_q;
  end

endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
  import sio_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(16'h03F0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [7:0]        lpt_status_i,
  output logic [7:0]        lpt_data_o,
  output logic [7:0]        lpt_ctrl_o,
  output logic [7:0]        lpt_mode_o,
  output logic              lpt_enable_o,
  output logic [7:0]        pwr_direct_o,
  output logic [7:0]        pwr_auto_o
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_ADDR + ADDR_W'(1);

  logic        sel_cfg, sel_data;
  logic        cfg_open, key_wait;
  logic [7:0]  index_q;
  logic [7:0]  cfg_rd;
  logic [15:0] lpt_base;
  logic        lpt_hit;
  logic [7:0]  lpt_rd;
  logic [7:0]  rd_next;

  assign sel_cfg  = (io_addr == CFG_ADDR);
  assign sel_data = (io_addr == DATA_ADDR);

  sio_lock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_wr  (io_wr && sel_cfg),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .key_wait (key_wait),
    .index_q  (index_q)
  );

  sio_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (io_wr && sel_data && cfg_open),
    .index    (index_q),
    .wdata    (io_wdata),
    .rd_val   (cfg_rd),
    .lpt_en   (lpt_enable_o),
    .lpt_base (lpt_base),
    .lpt_mode (lpt_mode_o),
    .pd_dir   (pwr_direct_o),
    .pd_auto  (pwr_auto_o)
  );

  sio_lpt_window #(.ADDR_W(ADDR_W)) u_lpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (lpt_enable_o),
    .base     (lpt_base),
    .addr     (io_addr),
    .wr       (io_wr && !sel_cfg && !sel_data),
    .wdata    (io_wdata),
    .status_i (lpt_status_i),
    .hit      (lpt_hit),
    .rd_val   (lpt_rd),
    .data_q   (lpt_data_o),
    .ctrl_q   (lpt_ctrl_o)
  );

  always_comb begin
    if (sel_cfg)       rd_next = cfg_open ? index_q : BUS_IDLE;
    else if (sel_data) rd_next = cfg_open ? cfg_rd  : BUS_IDLE;
    else if (lpt_hit)  rd_next = lpt_rd;
    else               rd_next = BUS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_rdata <= BUS_IDLE;
    else if (io_rd) io_rdata <= rd_next;
  end

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(16'h03F0)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_open,
  input logic              key_wait,
  input logic [15:0]       lpt_base,
  input logic              lpt_enable_o,
  input logic [7:0]        lpt_data_o,
  input logic [7:0]        lpt_ctrl_o
);

  logic cfg_wr;
  assign cfg_wr = io_wr && (io_addr == CFG_ADDR);

  // R1
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R2
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_wait && cfg_wr && io_wdata == 8'h23 |=> cfg_open);

  // R3
  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_wait && cfg_wr && io_wdata != 8'h23 |=> !cfg_open && !key_wait);

  // R4
  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open && io_rd && io_addr == CFG_ADDR + ADDR_W'(1) |=> io_rdata == 8'hFF);

  // R4
  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(lpt_base) && $stable(lpt_enable_o));

  // R5
  p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open && cfg_wr && io_wdata == 8'hBB |=> !cfg_open);

  // R13
  p_status_ro_r13: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_enable_o && io_wr && io_addr == ADDR_W'(lpt_base + 16'd1)
      && io_addr != CFG_ADDR && io_addr != CFG_ADDR + ADDR_W'(1)
    |=> $stable(lpt_data_o) && $stable(lpt_ctrl_o));

  // R14
  p_disabled_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !lpt_enable_o |=> $stable(lpt_data_o) && $stable(lpt_ctrl_o));

endmodule

bind sio_cfg_decoder sio_cfg_checker #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .cfg_open     (cfg_open),
  .key_wait     (key_wait),
  .lpt_base     (lpt_base),
  .lpt_enable_o (lpt_enable_o),
  .lpt_data_o   (lpt_data_o),
  .lpt_ctrl_o   (lpt_ctrl_o)
);

// File: tb/test_sio_cfg_decoder.sv
`timescale 1ns/1ps
module test_sio_cfg_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [7:0]  lpt_status_i = 8'h00;
  logic [7:0]  lpt_data_o, lpt_ctrl_o, lpt_mode_o, pwr_direct_o, pwr_auto_o;
  logic        lpt_enable_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_decoder i_sio_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .lpt_status_i(lpt_status_i),
    .lpt_data_o(lpt_data_o), .lpt_ctrl_o(lpt_ctrl_o), .lpt_mode_o(lpt_mode_o),
    .lpt_enable_o(lpt_enable_o), .pwr_direct_o(pwr_direct_o), .pwr_auto_o(pwr_auto_o)
  );

  // monitor: compares each registered read against the scoreboard
  always @(posedge clk) rd_seen <= io_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (io_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %02h expected %02h", t, io_rdata, e);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic cfg_set(logic [7:0] ix, logic [7:0] d);
    io_write(16'h03F0, ix);
    io_write(16'h03F1, d);
  endtask

  task automatic cfg_expect(logic [7:0] ix, logic [7:0] exp, string tag);
    io_write(16'h03F0, ix);
    io_read(16'h03F1, exp, tag);
  endtask

  task automatic unlock();
    io_write(16'h03F0, 8'h51);
    io_write(16'h03F0, 8'h23);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", {8'h0, io_rdata}, 16'h00FF);
    chk("R1 enable", {15'h0, lpt_enable_o}, 16'h0);
    chk("R1 mode", {8'h0, lpt_mode_o}, 16'h0);
    chk("R1 power", {pwr_direct_o, pwr_auto_o}, 16'h0);

    // R4 locked behaviour; R14 disabled window
    io_read(16'h03F1, 8'hFF, "R4 locked data port");
    io_read(16'h03F0, 8'hFF, "R4 locked index port");
    io_read(16'h0378, 8'hFF, "R14 disabled window");
    io_write(16'h0378, 8'h77);
    chk("R14 disabled write", {8'h0, lpt_data_o}, 16'h0);
    io_write(16'h03F0, 8'h07);
    io_write(16'h03F1, 8'h55);

    // R3 aborted key, then a lone second key byte
    io_write(16'h03F0, 8'h51);
    io_write(16'h03F0, 8'h44);
    io_write(16'h03F0, 8'h23);
    io_read(16'h03F1, 8'hFF, "R3 abort stays locked");
    io_write(16'h03F0, 8'h51);
    io_write(16'h03F0, 8'h51);
    io_write(16'h03F0, 8'h23);
    io_read(16'h03F1, 8'hFF, "R3 double first key");

    // R2 unlock; R4 locked write did not land in bank select
    unlock();
    io_write(16'h03F0, 8'h07);
    io_read(16'h03F0, 8'h07, "R2 index readback");
    io_read(16'h03F1, 8'h00, "R4 locked write dropped");

    // R6 bank gating
    cfg_set(8'h07, 8'h01);
    cfg_expect(8'h07, 8'h01, "R6 bank readback");
    cfg_set(8'h30, 8'h01);
    cfg_set(8'hF0, 8'h5A);
    cfg_expect(8'h30, 8'h00, "R6 foreign bank enable");
    cfg_expect(8'h60, 8'h00, "R6 foreign bank base");
    chk("R6 foreign write no effect", {7'h0, lpt_enable_o, lpt_mode_o}, 16'h0);

    cfg_set(8'h07, 8'h03);
    // R8 defaults
    cfg_expect(8'h60, 8'h03, "R8 base hi default");
    cfg_expect(8'h61, 8'h78, "R8 base lo default");
    // R9 mode
    cfg_set(8'hF0, 8'h8F);
    cfg_expect(8'hF0, 8'h8F, "R9 mode readback");
    chk("R9 mode pin", {8'h0, lpt_mode_o}, 16'h008F);
    // R10 power-down
    cfg_set(8'h22, 8'hA5);
    cfg_set(8'h23, 8'h3C);
    cfg_expect(8'h22, 8'hA5, "R10 direct readback");
    cfg_expect(8'h23, 8'h3C, "R10 auto readback");
    chk("R10 power pins", {pwr_direct_o, pwr_auto_o}, 16'hA53C);
    // R12 unimplemented
    cfg_set(8'h45, 8'hFF);
    cfg_expect(8'h45, 8'h00, "R12 unimplemented index");
    // R8 relocate, R7 enable
    cfg_set(8'h60, 8'h02);
    cfg_set(8'h30, 8'hFF);
    cfg_expect(8'h30, 8'h01, "R7 enable readback");
    chk("R7 enable pin", {15'h0, lpt_enable_o}, 16'h1);

    // R5 exit
    io_write(16'h03F0, 8'hBB);
    io_read(16'h03F1, 8'hFF, "R5 exit locks");
    io_write(16'h03F1, 8'h00);
    chk("R5 locked write ignored", {15'h0, lpt_enable_o}, 16'h1);

    // R13 window at 0x278
    lpt_status_i = 8'h5A;
    io_write(16'h0278, 8'hC3);
    chk("R13 data pin", {8'h0, lpt_data_o}, 16'h00C3);
    io_read(16'h0278, 8'hC3, "R13 data readback");
    io_read(16'h0279, 8'h5A, "R13 status read");
    io_write(16'h0279, 8'h11);
    chk("R13 status write ignored", {lpt_data_o, lpt_ctrl_o}, 16'hC300);
    io_write(16'h027A, 8'h0E);
    io_read(16'h027A, 8'h0E, "R13 control readback");
    chk("R13 control pin", {8'h0, lpt_ctrl_o}, 16'h000E);
    // R14 old base and out-of-window
    io_read(16'h0378, 8'hFF, "R14 old base unclaimed");
    io_read(16'h027B, 8'hFF, "R14 past window");
    io_write(16'h027B, 8'h99);
    chk("R14 outside write", {lpt_data_o, lpt_ctrl_o}, 16'hC30E);

    // R1 read data hold
    @(negedge clk);
    chk("R1 rdata holds", {8'h0, io_rdata}, 16'h00FF);

    // R11 soft reset
    unlock();
    cfg_set(8'h02, 8'h00);
    chk("R11 bit0 clear no effect", {8'h0, lpt_mode_o}, 16'h008F);
    cfg_set(8'h02, 8'h01);
    cfg_expect(8'h02, 8'h00, "R11 reset index reads zero");
    cfg_expect(8'h07, 8'h00, "R11 bank defaulted, still open");
    cfg_expect(8'h22, 8'h00, "R11 power defaulted");
    chk("R11 pins defaulted", {6'h0, lpt_enable_o, 1'b0, lpt_mode_o}, 16'h0);
    chk("R11 latches kept", {lpt_data_o, lpt_ctrl_o}, 16'hC30E);
    cfg_set(8'h07, 8'h03);
    cfg_expect(8'h60, 8'h03, "R11 base hi default");
    cfg_set(8'h30, 8'h01);
    io_write(16'h03F0, 8'hBB);
    io_read(16'h0378, 8'hC3, "R11 window back at default base");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule